// File: doc/BRIEF.md
# Scan-Programmed Tile Mesh

The block is an 8 by 8 array of identical logic tiles. Each tile holds one state bit and a 3-bit orientation, and it talks to its four neighbours. In its unrotated form a tile has two inputs, left and top. On each clock edge it stores the NAND of those two inputs. It drives the stored bit out of its right side and the complement of that bit out of its bottom side. The orientation decides which physical sides take the roles of left, top, right and bottom. It does this by combining a diagonal, a horizontal and a vertical mirror. Because every output is registered, no path through the mesh is purely combinational.

Eight external inputs feed the left edge of the array, one per row. Eight external outputs come from the right edge. All 64 state bits are linked in one serial chain. The chain starts at row 0 and runs left to right, then right to left on row 1, and so on. With the shared scan-enable set, the chain shifts one place per clock. Through this path the state is preset and read back. A broadcast 2-bit load code copies each tile's current state bit into one chosen orientation bit. The host therefore sets up orientations one plane at a time: it shifts in a plane of bits, then pulses the code for that plane.

Top module: `tile_mesh`

## Requirements
- R1: While rstN is low, every state bit and every orientation bit is 0, so meshOut and scanOut read 0. A full 64-shift readback after reset returns all zeros.
- R2: When scanEn is 1, each rising clock moves chain position k to position k+1, and scanIn enters position 0. scanOut always shows position 63. Position k is the tile at row k/8. Its column is k%8 on even rows and 7-k%8 on odd rows.
- R3: While scanEn is 1, meshIn and the neighbour values have no effect on any state bit.
- R4: When scanEn is 0, each tile stores NAND(canonical left input, canonical top input) on the clock edge. It drives its stored bit on its canonical right side and the inverse on its canonical bottom side. Its other two sides drive 0.
- R5: Orientation bit 0 swaps left with top and right with bottom. Bit 1 swaps left with right. Bit 2 swaps top with bottom. The swaps apply in the order bit 0, then bit 1, then bit 2. The result maps canonical sides onto physical sides.
- R6: On a clock edge, cfgCode 2'b11 copies each tile's pre-edge state bit into orientation bit 0. Code 2'b10 copies it into bit 1, and code 2'b01 copies it into bit 2. In the same edge the state bit updates as R2 or R4 says.
- R7: meshIn[r] drives the physical left input of the tile at row r, column 0. meshOut[r] is the physical right output of the tile at row r, column 7. Sides on the array edge that have no neighbour and no port read 0.
- R8: cfgCode 2'b00 leaves all orientation bits unchanged, including while the chain shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state and orientation bits |
| rstN | input | 1 | Asynchronous active-low reset |
| meshIn | input | 8 | Left-edge inputs, one per row |
| scanEn | input | 1 | 1 = shift the serial chain, 0 = normal evaluation |
| scanIn | input | 1 | Serial data into chain position 0 |
| cfgCode | input | 2 | Orientation plane load code (00 hold, 01 vertical, 10 horizontal, 11 diagonal) |
| meshOut | output | 8 | Right-edge outputs, one per row |
| scanOut | output | 1 | Chain position 63 (row 7, column 0) |

## Verification
The hardest state to reach from the ports is a mesh where each tile's three orientation bits are set independently. Every bit must first travel 64 places down the chain and then be committed by a load pulse. The stimulus builds each orientation plane as a 64-bit serial word, placing bit j for chain position 63-j. It shifts the word in, pulses the matching load code for one cycle, and repeats for the other two planes. It does this both with every tile set to each of the eight orientation values and with random per-tile orientations. It then runs normal cycles with varied edge inputs and scans the whole state out. A reference model in the bench predicts every output cycle by cycle. That model is built from a hand-written side table per orientation.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

  typedef enum logic [1:0] {
    SIDE_L = 2'd0,
    SIDE_T = 2'd1,
    SIDE_R = 2'd2,
    SIDE_B = 2'd3
  } side_e;

  typedef struct packed {
    logic shift;
    logic loadDiag;
    logic loadHoriz;
    logic loadVert;
  } meshStrobe_t;

  // Map a canonical side to a physical side for an orientation code.
  // Diagonal first (flip bit 0), then left/right, then top/bottom.
  function automatic logic [1:0] orientSide(input logic [1:0] side, input logic [2:0] orient);
    logic [1:0] s;
    s = side;
    if (orient[0]) s[0] = ~s[0];
    if (orient[1] && !s[0]) s[1] = ~s[1];
    if (orient[2] && s[0]) s[1] = ~s[1];
    return s;
  endfunction

endpackage

// File: rtl/mesh_ctrl.sv
module mesh_ctrl
  import mesh_pkg::*;
(
  input  logic        scanEn,
  input  logic [1:0]  cfgCode,
  output meshStrobe_t strb
);

  always_comb begin
    strb.shift     = scanEn;
    strb.loadDiag  = (cfgCode == 2'b11);
    strb.loadHoriz = (cfgCode == 2'b10);
    strb.loadVert  = (cfgCode == 2'b01);
  end

endmodule

// File: rtl/mesh_tile.sv
module mesh_tile
  import mesh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  meshStrobe_t strb,
  input  logic [3:0]  sideIn,
  input  logic        chainIn,
  output logic [3:0]  sideOut,
  output logic        stateQ
);

  logic [2:0] orientQ;
  logic [1:0] physL, physT, physR, physB;
  logic       nandVal;
  logic       anyLoad;

  always_comb begin
    physL   = orientSide(SIDE_L, orientQ);
    physT   = orientSide(SIDE_T, orientQ);
    physR   = orientSide(SIDE_R, orientQ);
    physB   = orientSide(SIDE_B, orientQ);
    nandVal = ~(sideIn[physL] & sideIn[physT]);
    anyLoad = strb.loadDiag | strb.loadHoriz | strb.loadVert;
  end

  always_comb begin
    sideOut        = '0;
    sideOut[physR] = stateQ;
    sideOut[physB] = ~stateQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= 1'b0;
      orientQ <= '0;
    end else begin
      stateQ <= strb.shift ? chainIn : nandVal;
      if (strb.loadDiag)  orientQ[0] <= stateQ;
      if (strb.loadHoriz) orientQ[1] <= stateQ;
      if (strb.loadVert)  orientQ[2] <= stateQ;
    end
  end

  a_r2_shift_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> stateQ == $past(chainIn));

  a_r4_nand_capture: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> stateQ == $past(nandVal));

  a_r6_diag_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDiag |=> orientQ[0] == $past(stateQ));

  a_r6_horiz_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadHoriz |=> orientQ[1] == $past(stateQ));

  a_r6_vert_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadVert |=> orientQ[2] == $past(stateQ));

  a_r8_orient_hold: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoad |=> $stable(orientQ));

endmodule

// File: rtl/mesh_array.sv
module mesh_array
  import mesh_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  meshStrobe_t     strb,
  input  logic [ROWS-1:0] meshIn,
  input  logic            scanIn,
  output logic [ROWS-1:0] meshOut,
  output logic            scanOut
);

  localparam int CELLS = ROWS * COLS;

  logic [3:0] tileOut [ROWS][COLS];
  logic       chainQ  [CELLS];

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < COLS; c++) begin : gCol
      localparam int POS = r * COLS + (((r % 2) == 0) ? c : (COLS - 1 - c));
      logic [3:0] tIn;
      logic       tChain;

      if (c == 0) begin : gLeftEdge
        assign tIn[SIDE_L] = meshIn[r];
      end else begin : gLeftNbr
        assign tIn[SIDE_L] = tileOut[r][c-1][SIDE_R];
      end

      if (r == 0) begin : gTopEdge
        assign tIn[SIDE_T] = 1'b0;
      end else begin : gTopNbr
        assign tIn[SIDE_T] = tileOut[r-1][c][SIDE_B];
      end

      if (c == COLS - 1) begin : gRightEdge
        assign tIn[SIDE_R] = 1'b0;
      end else begin : gRightNbr
        assign tIn[SIDE_R] = tileOut[r][c+1][SIDE_L];
      end

      if (r == ROWS - 1) begin : gBotEdge
        assign tIn[SIDE_B] = 1'b0;
      end else begin : gBotNbr
        assign tIn[SIDE_B] = tileOut[r+1][c][SIDE_T];
      end

      if (POS == 0) begin : gChainHead
        assign tChain = scanIn;
      end else begin : gChainLink
        assign tChain = chainQ[POS-1];
      end

      mesh_tile tile_i (
        .clk     (clk),
        .rstN    (rstN),
        .strb    (strb),
        .sideIn  (tIn),
        .chainIn (tChain),
        .sideOut (tileOut[r][c]),
        .stateQ  (chainQ[POS])
      );
    end

    assign meshOut[r] = tileOut[r][COLS-1][SIDE_R];
  end

  assign scanOut = chainQ[CELLS-1];

endmodule

// File: rtl/tile_mesh.sv
module tile_mesh
  import mesh_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ROWS-1:0] meshIn,
  input  logic            scanEn,
  input  logic            scanIn,
  input  logic [1:0]      cfgCode,
  output logic [ROWS-1:0] meshOut,
  output logic            scanOut
);

  meshStrobe_t strb;

  mesh_ctrl ctrl_i (
    .scanEn  (scanEn),
    .cfgCode (cfgCode),
    .strb    (strb)
  );

  mesh_array #(.ROWS(ROWS), .COLS(COLS)) array_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .meshIn  (meshIn),
    .scanIn  (scanIn),
    .meshOut (meshOut),
    .scanOut (scanOut)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (meshOut == '0 && scanOut == 1'b0));

endmodule

// File: tb/tile_mesh_tb_top.sv
module tile_mesh_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] meshIn = '0;
  logic       scanEn = 1'b0;
  logic       scanIn = 1'b0;
  logic [1:0] cfgCode = '0;
  logic [7:0] meshOut;
  logic       scanOut;

  always #2.5 clk = ~clk;

  tile_mesh dut_i (
    .clk(clk), .rstN(rstN), .meshIn(meshIn), .scanEn(scanEn),
    .scanIn(scanIn), .cfgCode(cfgCode), .meshOut(meshOut), .scanOut(scanOut)
  );

  typedef struct {
    int       cyc;
    bit [7:0] expOut;
    bit       expScan;
    string    tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit driverDone = 1'b0;

  // Reference model
  bit       mQ[8][8];
  bit [2:0] mO[8][8];

  // Physical side of a canonical side (0 L, 1 T, 2 R, 3 B), hand table.
  function automatic bit [1:0] physSide(bit [2:0] o, int canon);
    bit [7:0] m; // {B,R,T,L}
    case (o)
      3'd0: m = {2'd3, 2'd2, 2'd1, 2'd0};
      3'd1: m = {2'd2, 2'd3, 2'd0, 2'd1};
      3'd2: m = {2'd3, 2'd0, 2'd1, 2'd2};
      3'd3: m = {2'd0, 2'd3, 2'd2, 2'd1};
      3'd4: m = {2'd1, 2'd2, 2'd3, 2'd0};
      3'd5: m = {2'd2, 2'd1, 2'd0, 2'd3};
      3'd6: m = {2'd1, 2'd0, 2'd3, 2'd2};
      default: m = {2'd0, 2'd1, 2'd2, 2'd3};
    endcase
    return m[canon*2 +: 2];
  endfunction

  function automatic bit tileDrive(int r, int c, int p);
    if (p == int'(physSide(mO[r][c], 2))) return mQ[r][c];
    if (p == int'(physSide(mO[r][c], 3))) return ~mQ[r][c];
    return 1'b0;
  endfunction

  function automatic int chainRow(int k);
    return k / 8;
  endfunction

  function automatic int chainCol(int k);
    return ((k / 8) % 2 == 0) ? (k % 8) : (7 - k % 8);
  endfunction

  function automatic bit [7:0] expMesh();
    bit [7:0] v;
    for (int r = 0; r < 8; r++) v[r] = tileDrive(r, 7, 2);
    return v;
  endfunction

  task automatic modelStep(bit [7:0] mi, bit se, bit si, bit [1:0] cfg);
    bit       nQ[8][8];
    bit [2:0] nO[8][8];
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) begin
        bit [3:0] inp;
        inp[0] = (c == 0) ? mi[r] : tileDrive(r, c-1, 2);
        inp[1] = (r == 0) ? 1'b0 : tileDrive(r-1, c, 3);
        inp[2] = (c == 7) ? 1'b0 : tileDrive(r, c+1, 0);
        inp[3] = (r == 7) ? 1'b0 : tileDrive(r+1, c, 1);
        nQ[r][c] = ~(inp[physSide(mO[r][c], 0)] & inp[physSide(mO[r][c], 1)]);
        nO[r][c] = mO[r][c];
        if (cfg == 2'b11) nO[r][c][0] = mQ[r][c];
        if (cfg == 2'b10) nO[r][c][1] = mQ[r][c];
        if (cfg == 2'b01) nO[r][c][2] = mQ[r][c];
      end
    end
    if (se) begin
      for (int k = 0; k < 64; k++) begin
        nQ[chainRow(k)][chainCol(k)] = (k == 0) ? si : mQ[chainRow(k-1)][chainCol(k-1)];
      end
    end
    mQ = nQ;
    mO = nO;
  endtask

  // Driver: one clock of stimulus, expected result pushed for the next edge.
  task automatic tick(bit [7:0] mi, bit se, bit si, bit [1:0] cfg, string tag);
    item_t it;
    @(negedge clk);
    rstN = 1'b1;
    meshIn = mi;
    scanEn = se;
    scanIn = si;
    cfgCode = cfg;
    modelStep(mi, se, si, cfg);
    it.cyc = cyc + 1;
    it.expOut = expMesh();
    it.expScan = mQ[7][0];
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic resetFor(int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      @(negedge clk);
      rstN = 1'b0;
      meshIn = 8'($urandom);
      scanEn = 1'b0;
      cfgCode = 2'b00;
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++) begin
          mQ[r][c] = 1'b0;
          mO[r][c] = 3'd0;
        end
      it.cyc = cyc + 1;
      it.expOut = 8'h00;
      it.expScan = 1'b0;
      it.tag = "R1 reset";
      sb.push_back(it);
    end
  endtask

  // Bit j of the word ends at chain position 63-j after 64 shifts.
  task automatic shiftWord(bit [63:0] w, string tag);
    for (int j = 0; j < 64; j++) tick(8'($urandom), 1'b1, w[j], 2'b00, tag);
  endtask

  task automatic runFor(int n, string tag);
    for (int i = 0; i < n; i++) tick(8'($urandom), 1'b0, 1'b0, 2'b00, tag);
  endtask

  task automatic configure(bit [2:0] o [64]);
    bit [63:0] wd, wh, wv;
    for (int j = 0; j < 64; j++) begin
      wd[j] = o[63-j][0];
      wh[j] = o[63-j][1];
      wv[j] = o[63-j][2];
    end
    shiftWord(wd, "R2 R3 R8 diag plane");
    tick(8'($urandom), 1'b0, 1'b0, 2'b11, "R6 diag load");
    shiftWord(wh, "R2 R3 R8 horiz plane");
    tick(8'($urandom), 1'b0, 1'b0, 2'b10, "R6 horiz load");
    shiftWord(wv, "R2 R3 R8 vert plane");
    tick(8'($urandom), 1'b0, 1'b0, 2'b01, "R6 vert load");
  endtask

  // Monitor: samples 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    cyc++;
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      it = sb.pop_front();
      total += 2;
      if (meshOut !== it.expOut) begin
        bad++;
        $display("FAIL %s meshOut: actual=%h expected=%h (cycle %0d)", it.tag, meshOut, it.expOut, cyc);
      end
      if (scanOut !== it.expScan) begin
        bad++;
        $display("FAIL %s scanOut: actual=%b expected=%b (cycle %0d)", it.tag, scanOut, it.expScan, cyc);
      end
    end
  end

  initial begin
    bit [2:0] orients [64];
    resetFor(3);
    // R1: readback after reset is all zeros; R2: ordering via serpentine chain.
    shiftWord(64'h0, "R1 R2 readback");
    shiftWord(64'h8000_0000_0000_0001, "R2 single marker");
    shiftWord(64'hA5C3_0FF0_1234_9876, "R2 R3 pattern");
    runFor(20, "R4 R7 unrotated run");
    shiftWord(64'h0, "R2 R4 state readout");
    // R5: every tile in each orientation in turn.
    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 64; k++) orients[k] = 3'(o);
      configure(orients);
      shiftWord({$urandom, $urandom}, "R2 R5 preset");
      runFor(16, "R4 R5 R7 uniform orientation run");
      shiftWord(64'h0, "R5 readout");
    end
    // Mixed per-tile orientations.
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < 64; k++) orients[k] = 3'($urandom);
      configure(orients);
      runFor(24, "R4 R5 R7 mixed run");
      shiftWord({$urandom, $urandom}, "R8 hold while shifting");
      runFor(24, "R8 orientation kept");
    end
    // R1: reset in the middle of a configured run.
    resetFor(2);
    shiftWord(64'h0, "R1 readback after midrun reset");
    runFor(10, "R1 R4 orientation cleared run");
    driverDone = 1'b1;
  end

  initial begin
    wait (driverDone);
    repeat (4) @(posedge clk);
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule